// File: doc/BRIEF.md
# PHY Management Auto-Poll Sequencer

This block looks after a row of up to sixteen external PHY devices through a two-wire serial management link (MDC clock plus bidirectional MDIO data), with no processor involved. Once reset is released and polling is enabled, it runs an initialisation pass. In that pass it visits each PHY in turn, loads the local ability word into the PHY's auto-negotiation advertisement register, and then restarts auto-negotiation through the PHY's control register.

After the initialisation pass the block loops forever over the same PHY set. For each PHY it reads the basic status register and the link-partner ability register. It reduces the two words to four per-port flags: link up, running at 100 Mb/s, full duplex, and pause capable. These flags feed the switch core as four 16-bit vectors, one bit per port. If the polling strap is tied low, the sequencer stays silent and the vectors read as all ones, so that every port is treated as up, fast, full duplex and pause capable.

Top module: `mdio_autopoll`

## Requirements
- R1: Switch port p (0 to 15) is served by PHY address 8+p. Ports are visited in increasing order, so addresses run from 5'b01000 to 5'b10111.
- R2: Right after reset, for each port in order, the block issues a write of 16'h05E1 to register 4 and then a write of 16'h1200 to register 0. No read is issued until all 16 ports have been initialised.
- R3: Each management frame is, MSB first: 32 ones, start bits 01, opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround (10 on writes), and 16 data bits.
- R4: MDC is a square wave with a period of 2*MDC_DIV system clocks. MDIO is only updated on a falling MDC edge, and read data is sampled on a rising edge.
- R5: On a read, MDIO is released (mdio_oe_o low) from the first turnaround bit to the end of the frame.
- R6: After initialisation, each port is polled with a read of register 1 followed by a read of register 5. link_o[p] takes bit 2 of the register 1 value.
- R7: Let common = (register 5) AND 16'h05E1. Speed and duplex are resolved in this priority order: bit 8 gives 100/full, bit 7 gives 100/half, bit 6 gives 10/full, otherwise 10/half. speed_o=1 means 100 Mb/s and duplex_o=1 means full duplex. Both flags are 0 when the link is down.
- R8: pause_o[p] is 1 only when the link is up and bit 10 of common is set.
- R9: Polling never stops. After port 15 it wraps to port 0, and each round repeats the same register order.
- R10: With poll_en_i low, all four vectors read all ones and MDIO is never driven.
- R11: With poll_en_i high, all four vectors are all zeros from reset until the first poll result for each port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poll_en_i | input | 1 | Strap: enable initialisation and polling |
| mdio_i | input | 1 | Management data input from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe_o | output | 1 | Management data output enable |
| link_o | output | 16 | Per-port link up |
| speed_o | output | 16 | Per-port 100 Mb/s |
| duplex_o | output | 16 | Per-port full duplex |
| pause_o | output | 16 | Per-port pause capable |

## Verification
A model PHY in the bench answers every read. For the first poll round it returns directed partner words, one for each resolution branch: all abilities, 100/half only, 10/full only, 10/half only, link down with all ability bits set, and pause without full duplex. These show whether the decode follows the stated priority order and clears every flag when the link is down. Later rounds use random status and partner words with a biased link bit, which catches masking errors against the advertised word. Decoding every frame bit by bit also checks the address order, the initialisation writes, the wrap after port 15, the bus release on reads, and the MDC period. A second reset with the strap low confirms the all-ones defaults and a silent bus.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [4:0] REG_CTRL    = 5'd0;
  localparam logic [4:0] REG_STATUS  = 5'd1;
  localparam logic [4:0] REG_ADV     = 5'd4;
  localparam logic [4:0] REG_PARTNER = 5'd5;
  localparam logic [15:0] CTRL_ANEG_RESTART = 16'h1200;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic link;
    logic speed;
    logic duplex;
    logic pause;
  } port_stat_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (MDC_DIV > 1) ? $clog2(MDC_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(MDC_DIV - 1));
  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  localparam int FLEN    = PRE_LEN + 32;
  localparam int CW      = $clog2(FLEN + 1);
  localparam int TA_POS  = PRE_LEN + 14;
  localparam int DAT_POS = PRE_LEN + 16;

  logic [FLEN-1:0] sh_q;
  logic [CW-1:0]   cnt_q;
  logic            active_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      rd_q      <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_q && start_i) begin
        sh_q <= {{PRE_LEN{1'b1}}, 2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
                 (rd_i ? 2'b11 : 2'b10), (rd_i ? 16'h0000 : wdata_i)};
        cnt_q    <= '0;
        active_q <= 1'b1;
        rd_q     <= rd_i;
      end else if (active_q && fall_i) begin
        if (cnt_q == CW'(FLEN)) begin
          active_q  <= 1'b0;
          done_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
          mdio_o    <= 1'b1;
        end else begin
          mdio_o    <= sh_q[FLEN-1];
          mdio_oe_o <= !(rd_q && (cnt_q >= CW'(TA_POS)));
          sh_q      <= sh_q << 1;
          cnt_q     <= cnt_q + 1'b1;
        end
      end
      // bit k is driven when cnt becomes k+1; its rising edge follows
      if (active_q && rd_q && rise_i && (cnt_q > CW'(DAT_POS)))
        rdata_o <= {rdata_o[14:0], mdio_i};
    end
  end

  a_r4_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(mdio_o) && $stable(mdio_oe_o));

  a_r5_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && rd_q && (cnt_q > CW'(TA_POS))) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int          N_PORTS  = 16,
  parameter int          PHY_BASE = 8,
  parameter logic [15:0] ADV_WORD = 16'h05E1,
  localparam int         PW       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          done_i,
  input  logic [15:0]   rdata_i,
  output logic          start_o,
  output logic          rd_o,
  output logic [4:0]    phy_o,
  output logic [4:0]    reg_o,
  output logic [15:0]   wdata_o,
  output logic          upd_o,
  output logic [PW-1:0] upd_port_o,
  output logic [15:0]   upd_r1_o,
  output logic [15:0]   upd_r5_o
);
  seq_state_e    st_q;
  logic [PW-1:0] port_q;
  logic          init_q, step_q;
  logic [15:0]   r1_q;

  always_comb begin
    start_o = (st_q == ST_ISSUE);
    rd_o    = !init_q;
    phy_o   = 5'(PHY_BASE) + 5'(port_q);
    if (init_q) reg_o = step_q ? REG_CTRL : REG_ADV;
    else        reg_o = step_q ? REG_PARTNER : REG_STATUS;
    wdata_o = step_q ? CTRL_ANEG_RESTART : ADV_WORD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      port_q     <= '0;
      init_q     <= 1'b1;
      step_q     <= 1'b0;
      r1_q       <= '0;
      upd_o      <= 1'b0;
      upd_port_o <= '0;
      upd_r1_o   <= '0;
      upd_r5_o   <= '0;
    end else begin
      upd_o <= 1'b0;
      unique case (st_q)
        ST_IDLE:  if (en_i) st_q <= ST_ISSUE;
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          st_q <= en_i ? ST_ISSUE : ST_IDLE;
          if (!init_q && !step_q) r1_q <= rdata_i;
          if (!init_q && step_q) begin
            upd_o      <= 1'b1;
            upd_port_o <= port_q;
            upd_r1_o   <= r1_q;
            upd_r5_o   <= rdata_i;
          end
          if (step_q) begin
            step_q <= 1'b0;
            if (port_q == PW'(N_PORTS - 1)) begin
              port_q <= '0;
              init_q <= 1'b0;
            end else begin
              port_q <= port_q + 1'b1;
            end
          end else begin
            step_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_phy_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (phy_o >= 5'(PHY_BASE)) && (phy_o < 5'(PHY_BASE + N_PORTS)));

  a_r2_no_update_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> !init_q);

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && done_i && step_q && port_q == PW'(N_PORTS - 1))
      |=> (port_q == '0) && !init_q);
endmodule

// File: rtl/mdio_decode.sv
module mdio_decode
  import mdio_pkg::*;
#(
  parameter logic [15:0] ADV_WORD = 16'h05E1
) (
  input  logic [15:0] r1_i,
  input  logic [15:0] r5_i,
  output port_stat_t  stat_o
);
  logic [15:0] common;

  always_comb begin
    common = r5_i & ADV_WORD;
    stat_o = '0;
    if (r1_i[2]) begin
      stat_o.link = 1'b1;
      if (common[8])      begin stat_o.speed = 1'b1; stat_o.duplex = 1'b1; end
      else if (common[7]) begin stat_o.speed = 1'b1; stat_o.duplex = 1'b0; end
      else if (common[6]) begin stat_o.speed = 1'b0; stat_o.duplex = 1'b1; end
      stat_o.pause = common[10];
    end
  end
endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
  import mdio_pkg::*;
#(
  parameter int          N_PORTS  = 16,
  parameter int          PHY_BASE = 8,
  parameter int          MDC_DIV  = 2,
  parameter int          PRE_LEN  = 32,
  parameter logic [15:0] ADV_WORD = 16'h05E1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               poll_en_i,
  input  logic               mdio_i,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [N_PORTS-1:0] link_o,
  output logic [N_PORTS-1:0] speed_o,
  output logic [N_PORTS-1:0] duplex_o,
  output logic [N_PORTS-1:0] pause_o
);
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic          rise, fall, start, rd, done, upd;
  logic [4:0]    phy, regn;
  logic [15:0]   wdata, rdata, upd_r1, upd_r5;
  logic [PW-1:0] upd_port;
  port_stat_t    new_stat;
  port_stat_t    stat_q [N_PORTS];

  mdio_clkgen #(.MDC_DIV(MDC_DIV)) u_clk (
    .clk_i, .rst_ni, .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .start_i(start), .rd_i(rd),
    .phy_i(phy), .reg_i(regn), .wdata_i(wdata), .mdio_i, .mdio_o, .mdio_oe_o,
    .done_o(done), .rdata_o(rdata)
  );

  mdio_seq #(.N_PORTS(N_PORTS), .PHY_BASE(PHY_BASE), .ADV_WORD(ADV_WORD)) u_seq (
    .clk_i, .rst_ni, .en_i(poll_en_i), .done_i(done), .rdata_i(rdata),
    .start_o(start), .rd_o(rd), .phy_o(phy), .reg_o(regn), .wdata_o(wdata),
    .upd_o(upd), .upd_port_o(upd_port), .upd_r1_o(upd_r1), .upd_r5_o(upd_r5)
  );

  mdio_decode #(.ADV_WORD(ADV_WORD)) u_dec (
    .r1_i(upd_r1), .r5_i(upd_r5), .stat_o(new_stat)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            stat_q[p] <= '0;
      else if (upd && upd_port == PW'(p))     stat_q[p] <= new_stat;
    end
    // polling strap off: report every port as fully capable
    assign link_o[p]   = poll_en_i ? stat_q[p].link   : 1'b1;
    assign speed_o[p]  = poll_en_i ? stat_q[p].speed  : 1'b1;
    assign duplex_o[p] = poll_en_i ? stat_q[p].duplex : 1'b1;
    assign pause_o[p]  = poll_en_i ? stat_q[p].pause  : 1'b1;

    a_r7_down_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (poll_en_i && !link_o[p]) |-> !speed_o[p] && !duplex_o[p] && !pause_o[p]);
  end

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_en_i |-> !mdio_oe_o);
endmodule

// File: tb/tb_mdio_autopoll.sv
module tb_mdio_autopoll;
  localparam int NP = 16;
  localparam int DIV = 2;
  localparam logic [15:0] ADV = 16'h05E1;

  logic clk = 1'b0, rst_n = 1'b0, poll_en = 1'b1, mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe;
  logic [NP-1:0] link, speed, duplex, pause;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  mdio_autopoll dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_en_i(poll_en), .mdio_i(mdio_i),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .link_o(link), .speed_o(speed), .duplex_o(duplex), .pause_o(pause)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {link, speed, duplex, pause} from the R6/R7/R8 rules
  function automatic logic [3:0] exp_stat(input logic [15:0] r1, input logic [15:0] r5);
    logic [15:0] c;
    c = r5 & ADV;
    if (!r1[2]) return 4'b0000;
    if (c[8]) return {3'b111, c[10]};
    if (c[7]) return {3'b110, c[10]};
    if (c[6]) return {3'b101, c[10]};
    return {3'b100, c[10]};
  endfunction

  // monitor / PHY model state
  int frame_cnt = 0, pos = 0, cyc = 0, last_rise = 0, period = 0, oe_cnt = 0;
  logic [63:0] fr;
  logic mdc_prev = 1'b0, cur_rd = 1'b0, oe_err = 1'b0, pend = 1'b0;
  int pend_port = 0;
  logic [15:0] cur1 [NP];
  logic [15:0] cur5 [NP];
  logic [15:0] serve;

  task automatic pick_vals(input int port, input int round);
    if (round == 0 && port < 6) begin
      case (port)
        0: begin cur1[port] = 16'h0004; cur5[port] = 16'h05E1; end
        1: begin cur1[port] = 16'h782D; cur5[port] = 16'h0080; end
        2: begin cur1[port] = 16'h0004; cur5[port] = 16'h0040; end
        3: begin cur1[port] = 16'h0004; cur5[port] = 16'h0020; end
        4: begin cur1[port] = 16'hFFFB; cur5[port] = 16'hFFFF; end
        default: begin cur1[port] = 16'h0004; cur5[port] = 16'h04A0; end
      endcase
    end else begin
      cur1[port] = 16'($urandom);
      cur1[port][2] = ($urandom % 4) != 0;
      cur5[port] = 16'($urandom);
    end
  endtask

  task automatic check_frame(input int k);
    int port; logic is_rd; logic [4:0] rg; logic [15:0] wd;
    if (k < 2 * NP) begin
      port = k / 2; is_rd = 1'b0;
      rg = (k % 2) ? 5'd0 : 5'd4;
      wd = (k % 2) ? 16'h1200 : ADV;
    end else begin
      port = ((k - 2 * NP) / 2) % NP; is_rd = 1'b1;
      rg = (k % 2) ? 5'd5 : 5'd1;
      wd = 16'h0;
    end
    chk(fr[63:32] == 32'hFFFF_FFFF, "R3 preamble", fr[63:32], 32'hFFFF_FFFF);
    chk(fr[31:30] == 2'b01, "R3 start", fr[31:30], 2'b01);
    chk(fr[29:28] == (is_rd ? 2'b10 : 2'b01), "R3 opcode", fr[29:28], is_rd ? 2'b10 : 2'b01);
    chk(fr[27:23] == 5'(8 + port), "R1 phy address", fr[27:23], 8 + port);
    if (!is_rd) begin
      chk(fr[22:18] == rg, "R2 init register", fr[22:18], rg);
      chk(fr[17:16] == 2'b10, "R3 write turnaround", fr[17:16], 2'b10);
      chk(fr[15:0] == wd, "R2 init data", fr[15:0], wd);
    end else begin
      chk(fr[22:18] == rg, (k >= 4 * NP) ? "R9 poll register after wrap" : "R6 poll register",
          fr[22:18], rg);
      chk(!oe_err, "R5 bus released on read", oe_err, 0);
    end
    chk(period == 2 * DIV, "R4 mdc period", period, 2 * DIV);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      pos = 0; pend = 1'b0; mdio_i = 1'b1; mdc_prev = mdc;
    end else begin
      if (mdio_oe) oe_cnt++;
      if (mdc && !mdc_prev) begin
        period = cyc - last_rise; last_rise = cyc;
        if (pos != 0 || mdio_oe) begin
          if (pos == 0) begin
            oe_err = 1'b0;
            if (pend) begin
              pend = 1'b0;
              chk(link[pend_port] == exp_stat(cur1[pend_port], cur5[pend_port])[3], "R6 link",
                  link[pend_port], exp_stat(cur1[pend_port], cur5[pend_port])[3]);
              chk(speed[pend_port] == exp_stat(cur1[pend_port], cur5[pend_port])[2], "R7 speed",
                  speed[pend_port], exp_stat(cur1[pend_port], cur5[pend_port])[2]);
              chk(duplex[pend_port] == exp_stat(cur1[pend_port], cur5[pend_port])[1], "R7 duplex",
                  duplex[pend_port], exp_stat(cur1[pend_port], cur5[pend_port])[1]);
              chk(pause[pend_port] == exp_stat(cur1[pend_port], cur5[pend_port])[0], "R8 pause",
                  pause[pend_port], exp_stat(cur1[pend_port], cur5[pend_port])[0]);
            end
          end
          if (cur_rd && pos >= 46 && mdio_oe) oe_err = 1'b1;
          fr = {fr[62:0], (mdio_oe ? mdio_o : mdio_i)};
          pos++;
          if (pos == 36) cur_rd = (fr[1:0] == 2'b10);
          if (pos == 46 && cur_rd) begin
            if (fr[4:0] == 5'd1) begin
              pick_vals(int'(fr[9:5]) - 8, (frame_cnt - 2 * NP) / (2 * NP));
              serve = cur1[int'(fr[9:5]) - 8];
            end else begin
              serve = cur5[int'(fr[9:5]) - 8];
            end
          end
          if (pos == 64) begin
            check_frame(frame_cnt);
            if (cur_rd && fr[22:18] == 5'd5) begin
              pend = 1'b1; pend_port = int'(fr[27:23]) - 8;
            end
            frame_cnt++;
            pos = 0; cur_rd = 1'b0;
          end
        end
      end else if (!mdc && mdc_prev) begin
        if (cur_rd && pos == 47) mdio_i = 1'b0;
        else if (cur_rd && pos >= 48 && pos <= 63) mdio_i = serve[15 - (pos - 48)];
        else mdio_i = 1'b1;
      end
      mdc_prev = mdc;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(link == '0 && speed == '0 && duplex == '0 && pause == '0, "R11 reset zeros",
        {link, speed, duplex, pause}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(link == '0 && pause == '0, "R11 zeros after release", {link, pause}, 0);
    wait (frame_cnt >= 2 * NP + 6 * NP);
    @(negedge clk);
    // strap off: all-ones defaults, silent bus
    rst_n = 1'b0; poll_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(link == '1 && speed == '1 && duplex == '1 && pause == '1, "R10 all ones",
        {link, speed, duplex, pause}, {(4 * NP){1'b1}});
    base = oe_cnt;
    repeat (2000) @(negedge clk);
    chk(oe_cnt == base, "R10 bus never driven", oe_cnt - base, 0);
    chk(link == '1 && duplex == '1, "R10 still all ones", {link, duplex}, {(2 * NP){1'b1}});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", frame_cnt);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule